// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt RAM

A synchronous two-port word memory. A left and a right agent can each read or write any word on every clock. Each agent can write only the upper half, only the lower half, or both halves of a word. The two highest word addresses also act as a message path between the agents. A write into the other agent's slot raises that agent's interrupt. The interrupt stays raised until its owner reads the slot.

The interrupt can be suppressed. An external arbiter drives a busy input per side. While its busy input is high, an agent's mailbox write still stores the data but cannot raise the peer's interrupt. The same busy input decides which side wins when both sides write the same half of the same word in one cycle.

Read data comes back on a separate bus per side, with a one-cycle valid strobe, one clock after the request. This return path is valid-only and has no ready signal. The consumer must take the word in the cycle the strobe is high, and there is no back-pressure. The interrupt outputs are active-low flags, not a stream.

Top module: `dpmb_ram`

## Requirements
- R1: With address width A, word address 2^A-1 is the right side's mailbox and 2^A-2 is the left side's mailbox (0xFF and 0xFE for A=8).
- R2: While a side's enable is low, that side writes nothing, returns no read and has no effect on either interrupt, whatever its other inputs are.
- R3: A read is a cycle with enable high, write-select low and output-enable high. Exactly then, the side's read-valid is high on the following cycle, with the addressed word on its read bus. With output-enable low there is no valid strobe and the cycle does not count as a read for the interrupt rules.
- R4: On a write, the upper-lane select enables bits [15:8] and the lower-lane select enables bits [7:0]. A lane whose select is low keeps its old contents.
- R5: A write with at least one lane selected, by the left side to the right mailbox, drives the right interrupt low on the next cycle. The same holds for the right side writing the left mailbox.
- R6: An owner's read of its own mailbox returns its interrupt output to high on the next cycle.
- R7: A side reading the other side's mailbox does not clear the other side's interrupt.
- R8: A write to the peer's mailbox while the writer's busy input is high stores the data but leaves the peer's interrupt unchanged.
- R9: A side writing its own mailbox does not change its own interrupt.
- R10: When a set and a clear of the same interrupt fall in one cycle, the interrupt is low afterwards.
- R11: When both sides write the same lane of the same word in one cycle, the left data is stored if left busy is low. The right data is stored if left busy is high.
- R12: Reset (active-low, synchronous) drives both interrupt outputs high and both read-valid outputs low.
- R13: A read returns the word as it was before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left access enable |
| l_we | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable for reads |
| l_ub | input | 1 | Left upper-lane select |
| l_lb | input | 1 | Left lower-lane select |
| l_busy | input | 1 | Left busy from arbiter |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read-valid strobe |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right access enable |
| r_we | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right output enable for reads |
| r_ub | input | 1 | Right upper-lane select |
| r_lb | input | 1 | Right lower-lane select |
| r_busy | input | 1 | Right busy from arbiter |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read-valid strobe |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
A wrong mailbox decode or a stuck interrupt register shows on the affected irq output one cycle after the offending write or read. It stays wrong until the next legal set or clear. A wrong lane mask, collision choice or read-before-write ordering stays hidden in storage until the word is read back. It then appears on the read bus one cycle after that read. A broken read qualifier shows at once as a missing or extra valid strobe.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             rd;
    logic [LANES-1:0] lane_we;
    logic             set_peer;
    logic             clr_own;
  } port_cmd_t;
endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OWN_MB  = '1,
  parameter logic [ADDR_W-1:0] PEER_MB = '1
) (
  input  logic              en,
  input  logic              we,
  input  logic              oe,
  input  logic              ub,
  input  logic              lb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output port_cmd_t         cmd
);
  logic wr_any;

  always_comb begin
    cmd.rd       = en & ~we & oe;
    cmd.lane_we  = {ub, lb} & {LANES{en & we}};
    wr_any       = |cmd.lane_we;
    cmd.set_peer = wr_any & ~busy & (addr == PEER_MB);
    cmd.clr_own  = cmd.rd & (addr == OWN_MB);
  end
endmodule

// File: rtl/dpmb_store.sv
module dpmb_store
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              l_rd,
  input  logic              r_rd,
  input  logic [LANES-1:0]  l_lane_we,
  input  logic [LANES-1:0]  r_lane_we,
  input  logic              l_busy,
  output logic [DATA_W-1:0] l_rdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              l_rvalid,
  output logic              r_rvalid
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic same_addr;
  assign same_addr = (l_addr == r_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] l_q, r_q;
    logic coll, l_do, r_do;

    assign coll = l_lane_we[g] & r_lane_we[g] & same_addr;
    assign l_do = l_lane_we[g] & ~(coll & l_busy);
    assign r_do = r_lane_we[g] & ~(coll & ~l_busy);

    always_ff @(posedge clk) begin
      if (l_do) lane_mem[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
      if (r_do) lane_mem[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
      if (l_rd) l_q <= lane_mem[l_addr];
      if (r_rd) r_q <= lane_mem[r_addr];
    end

    assign l_rdata[g*LANE_W +: LANE_W] = l_q;
    assign r_rdata[g*LANE_W +: LANE_W] = r_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rvalid <= 1'b0;
      r_rvalid <= 1'b0;
    end else begin
      l_rvalid <= l_rd;
      r_rvalid <= r_rd;
    end
  end
endmodule

// File: rtl/dpmb_irq_flag.sv
module dpmb_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;
    else if (clr) irq_n <= 1'b1;
  end
endmodule

// File: rtl/dpmb_ram.sv
module dpmb_ram
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_ub,
  input  logic              l_lb,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_ub,
  input  logic              r_lb,
  input  logic              r_busy,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] MB_RIGHT = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MB_LEFT  = MB_RIGHT - 1'b1;

  port_cmd_t l_cmd, r_cmd;

  dpmb_port_dec #(.ADDR_W(ADDR_W), .OWN_MB(MB_LEFT), .PEER_MB(MB_RIGHT)) i_l_dec (
    .en(l_en), .we(l_we), .oe(l_oe), .ub(l_ub), .lb(l_lb),
    .busy(l_busy), .addr(l_addr), .cmd(l_cmd)
  );

  dpmb_port_dec #(.ADDR_W(ADDR_W), .OWN_MB(MB_RIGHT), .PEER_MB(MB_LEFT)) i_r_dec (
    .en(r_en), .we(r_we), .oe(r_oe), .ub(r_ub), .lb(r_lb),
    .busy(r_busy), .addr(r_addr), .cmd(r_cmd)
  );

  dpmb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .r_addr(r_addr),
    .l_wdata(l_wdata), .r_wdata(r_wdata),
    .l_rd(l_cmd.rd), .r_rd(r_cmd.rd),
    .l_lane_we(l_cmd.lane_we), .r_lane_we(r_cmd.lane_we),
    .l_busy(l_busy),
    .l_rdata(l_rdata), .r_rdata(r_rdata),
    .l_rvalid(l_rvalid), .r_rvalid(r_rvalid)
  );

  dpmb_irq_flag i_l_irq (
    .clk(clk), .rst_n(rst_n),
    .set(r_cmd.set_peer), .clr(l_cmd.clr_own), .irq_n(l_irq_n)
  );

  dpmb_irq_flag i_r_irq (
    .clk(clk), .rst_n(rst_n),
    .set(l_cmd.set_peer), .clr(r_cmd.clr_own), .irq_n(r_irq_n)
  );
endmodule

// File: rtl/dpmb_chk.sv
module dpmb_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic              l_we,
  input logic              l_oe,
  input logic              l_ub,
  input logic              l_lb,
  input logic              l_busy,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_irq_n,
  input logic              r_en,
  input logic              r_we,
  input logic              r_oe,
  input logic              r_ub,
  input logic              r_lb,
  input logic              r_busy,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic l_read, r_read, set_r, set_l, clr_r, clr_l;
  assign l_read = l_en && !l_we && l_oe;
  assign r_read = r_en && !r_we && r_oe;
  assign set_r  = l_en && l_we && (l_ub || l_lb) && !l_busy && (l_addr == TOP_ADDR);
  assign set_l  = r_en && r_we && (r_ub || r_lb) && !r_busy && (r_addr == TOP_ADDR - 1'b1);
  assign clr_r  = r_read && (r_addr == TOP_ADDR);
  assign clr_l  = l_read && (l_addr == TOP_ADDR - 1'b1);

  // R5
  r_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set_r |=> !r_irq_n);
  // R5
  l_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set_l |=> !l_irq_n);
  // R6
  r_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_r && !set_r |=> r_irq_n);
  // R8
  r_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !set_r && r_irq_n |=> r_irq_n);
  // R9
  l_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !set_l && l_irq_n |=> l_irq_n);
  // R7
  r_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !clr_r && !r_irq_n |=> !r_irq_n);
  // R3
  l_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n) l_read |=> l_rvalid);
  // R3
  l_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n) !l_read |=> !l_rvalid);
  // R3
  r_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n) r_read |=> r_rvalid);
  // R3
  r_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !r_read |=> $stable(r_rdata));
  // R3
  l_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !l_read |=> $stable(l_rdata));
endmodule

bind dpmb_ram dpmb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb), .l_busy(l_busy),
  .l_addr(l_addr), .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_irq_n(l_irq_n),
  .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb), .r_busy(r_busy),
  .r_addr(r_addr), .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_irq_n(r_irq_n)
);

// File: tb/test_dpmb_ram.sv
`timescale 1ns/100ps
module test_dpmb_ram;
  // op: 0 idle (enable low, other controls active), 1 write, 2 read, 3 read with output-enable low
  typedef struct packed {
    logic [1:0]  lop;  logic [7:0] la; logic [15:0] ld; logic [1:0] lln; logic lbz;
    logic [1:0]  rop;  logic [7:0] ra; logic [15:0] rd; logic [1:0] rln; logic rbz;
    logic        lirq; logic rirq;
    logic [15:0] lexp; logic [15:0] rexp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd1,8'h10,16'hA1B2,2'b11,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h0000,16'h0000, 4'd4},  // R4 full write
    '{2'd0,8'h00,16'h0000,2'b00,1'b0, 2'd2,8'h10,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h0000,16'hA1B2, 4'd3},  // R3
    '{2'd1,8'h10,16'hFFCC,2'b01,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h0000,16'h0000, 4'd4},  // R4 lower lane
    '{2'd2,8'h10,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'hA1CC,16'h0000, 4'd4},  // R4
    '{2'd0,8'h00,16'h0000,2'b00,1'b0, 2'd1,8'h10,16'h55EE,2'b10,1'b0, 1'b1,1'b1, 16'h0000,16'h0000, 4'd4},  // R4 upper lane
    '{2'd2,8'h10,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h55CC,16'h0000, 4'd4},  // R4
    '{2'd1,8'hFF,16'h1234,2'b11,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b0, 16'h0000,16'h0000, 4'd5},  // R5 R1
    '{2'd2,8'hFF,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b0, 16'h1234,16'h0000, 4'd7},  // R7
    '{2'd0,8'h00,16'h0000,2'b00,1'b0, 2'd2,8'hFF,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h0000,16'h1234, 4'd6},  // R6
    '{2'd0,8'h00,16'h0000,2'b00,1'b0, 2'd1,8'hFE,16'h5678,2'b11,1'b1, 1'b1,1'b1, 16'h0000,16'h0000, 4'd8},  // R8
    '{2'd2,8'hFE,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h5678,16'h0000, 4'd8},  // R8 data stored
    '{2'd0,8'h00,16'h0000,2'b00,1'b0, 2'd1,8'hFE,16'h9ABC,2'b11,1'b0, 1'b0,1'b1, 16'h0000,16'h0000, 4'd5},  // R5 R1
    '{2'd1,8'hFE,16'h1111,2'b11,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b0,1'b1, 16'h0000,16'h0000, 4'd9},  // R9
    '{2'd2,8'hFE,16'h0000,2'b00,1'b0, 2'd1,8'hFE,16'h2222,2'b11,1'b0, 1'b0,1'b1, 16'h1111,16'h0000, 4'd10}, // R10 R13
    '{2'd2,8'hFE,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h2222,16'h0000, 4'd6},  // R6
    '{2'd1,8'h20,16'hAAAA,2'b11,1'b0, 2'd1,8'h20,16'hBBBB,2'b11,1'b0, 1'b1,1'b1, 16'h0000,16'h0000, 4'd11}, // R11
    '{2'd0,8'h00,16'h0000,2'b00,1'b0, 2'd2,8'h20,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h0000,16'hAAAA, 4'd11}, // R11
    '{2'd1,8'h21,16'hCCCC,2'b11,1'b1, 2'd1,8'h21,16'hDDDD,2'b11,1'b0, 1'b1,1'b1, 16'h0000,16'h0000, 4'd11}, // R11 busy
    '{2'd2,8'h21,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'hDDDD,16'h0000, 4'd11}, // R11
    '{2'd0,8'h00,16'h0000,2'b00,1'b0, 2'd1,8'hFE,16'h3333,2'b11,1'b0, 1'b0,1'b1, 16'h0000,16'h0000, 4'd5},  // R5
    '{2'd3,8'hFE,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b0,1'b1, 16'h0000,16'h0000, 4'd3},  // R3 oe low
    '{2'd2,8'hFE,16'h0000,2'b00,1'b0, 2'd0,8'h00,16'h0000,2'b00,1'b0, 1'b1,1'b1, 16'h3333,16'h0000, 4'd6},  // R6
    '{2'd0,8'h10,16'h0000,2'b11,1'b0, 2'd0,8'h10,16'h0000,2'b11,1'b0, 1'b1,1'b1, 16'h0000,16'h0000, 4'd2},  // R2
    '{2'd2,8'h10,16'h0000,2'b00,1'b0, 2'd0,8'hFE,16'h0000,2'b11,1'b0, 1'b1,1'b1, 16'h55CC,16'h0000, 4'd2},  // R2
    '{2'd0,8'hFF,16'h7777,2'b11,1'b0, 2'd0,8'hFE,16'h7777,2'b11,1'b0, 1'b1,1'b1, 16'h0000,16'h0000, 4'd2}   // R2
  };

  logic clk = 1'b0;
  logic rst_n;
  logic l_en, l_we, l_oe, l_ub, l_lb, l_busy;
  logic r_en, r_we, r_oe, r_ub, r_lb, r_busy;
  logic [7:0]  l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_irq_n, r_irq_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dpmb_ram #(.ADDR_W(8), .DATA_W(16)) i_dpmb_ram (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb), .l_busy(l_busy),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb), .r_busy(r_busy),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_irq_n(r_irq_n)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_all();
    l_en = 0; l_we = 0; l_oe = 0; l_ub = 0; l_lb = 0; l_busy = 0; l_addr = 0; l_wdata = 0;
    r_en = 0; r_we = 0; r_oe = 0; r_ub = 0; r_lb = 0; r_busy = 0; r_addr = 0; r_wdata = 0;
  endtask

  task automatic drive_side(input logic [1:0] op, output logic en, output logic we, output logic oe);
    case (op)
      2'd0: begin en = 0; we = 1; oe = 1; end
      2'd1: begin en = 1; we = 1; oe = 0; end
      2'd2: begin en = 1; we = 0; oe = 1; end
      default: begin en = 1; we = 0; oe = 0; end
    endcase
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_all();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12", "l_irq_n", {15'd0, l_irq_n}, 16'd1);
    check("R12", "r_irq_n", {15'd0, r_irq_n}, 16'd1);
    check("R12", "l_rvalid", {15'd0, l_rvalid}, 16'd0);
    check("R12", "r_rvalid", {15'd0, r_rvalid}, 16'd0);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      vec_t v;
      v = VECS[i];
      tag = $sformatf("R%0d", v.req);
      @(negedge clk);
      drive_side(v.lop, l_en, l_we, l_oe);
      drive_side(v.rop, r_en, r_we, r_oe);
      {l_ub, l_lb} = v.lln; l_busy = v.lbz; l_addr = v.la; l_wdata = v.ld;
      {r_ub, r_lb} = v.rln; r_busy = v.rbz; r_addr = v.ra; r_wdata = v.rd;
      @(posedge clk);
      #1;
      check(tag, $sformatf("v%0d l_irq_n", i), {15'd0, l_irq_n}, {15'd0, v.lirq});
      check(tag, $sformatf("v%0d r_irq_n", i), {15'd0, r_irq_n}, {15'd0, v.rirq});
      // R3 valid strobe follows a qualified read
      check("R3", $sformatf("v%0d l_rvalid", i), {15'd0, l_rvalid}, {15'd0, v.lop == 2'd2});
      check("R3", $sformatf("v%0d r_rvalid", i), {15'd0, r_rvalid}, {15'd0, v.rop == 2'd2});
      if (v.lop == 2'd2) check(tag, $sformatf("v%0d l_rdata", i), l_rdata, v.lexp);
      if (v.rop == 2'd2) check(tag, $sformatf("v%0d r_rdata", i), r_rdata, v.rexp);
    end

    // R5: a write with no lane selected does not raise the peer interrupt
    @(negedge clk);
    idle_all();
    l_en = 1; l_we = 1; l_addr = 8'hFF; l_wdata = 16'h4444;
    @(posedge clk);
    #1;
    check("R5", "no-lane write r_irq_n", {15'd0, r_irq_n}, 16'd1);

    // R12: reset clears a raised interrupt
    @(negedge clk);
    l_ub = 1; l_lb = 1;
    @(posedge clk);
    #1;
    check("R5", "pre-reset r_irq_n", {15'd0, r_irq_n}, 16'd0);
    @(negedge clk);
    idle_all();
    rst_n = 0;
    @(posedge clk);
    #1;
    check("R12", "reset r_irq_n", {15'd0, r_irq_n}, 16'd1);
    @(negedge clk);
    rst_n = 1;
    // R1: data written before reset stays in storage
    r_en = 1; r_oe = 1; r_addr = 8'hFF;
    @(posedge clk);
    #1;
    check("R1", "right mailbox data", r_rdata, 16'h4444);
    @(negedge clk);
    idle_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule